// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a video output from a set of programmed values. A horizontal counter runs over the pixels of a line and a vertical counter runs over the lines of a frame. From these two counts it derives:

- horizontal and vertical sync pulses, each with a selectable polarity;
- blanking flags for both axes;
- an active-picture flag;
- a field bit used for interlaced scanning;
- three single-cycle raster interrupts.

The counters move only on cycles where the pixel-clock enable is high. This lets the block run on a fast system clock while stepping at the pixel rate.

The programmed values are the last pixel index of a line and the last line index of a frame, a border window for each axis, and the sync pulse widths. Two vertical interrupts each fire at the start of a chosen line. A horizontal interrupt fires at a chosen pixel position, either on one selected line or on every line. A packed status word gives software-style visibility of the blanking state, the field and the current line.

Top module: `raster_timer`

## Requirements
- R1: The pixel count starts at 0 and advances by one on each cycle with `pix_en` high. On the step after it reaches or passes `h_total`, it returns to 0 and the line advances. With `pix_en` low, every count holds.
- R2: `line_num` gives the current line. On a line wrap where the line is at or beyond `v_total`, the line returns to 0.
- R3: On each frame wrap, `field` inverts when `interlace` is 1 and is cleared when `interlace` is 0. After reset it is 0.
- R4: `hblank` is low exactly when `h_brd_start <= pixel < h_brd_end`. `vblank` is low exactly when `v_brd_start <= line < v_brd_end`.
- R5: A sync pulse is asserted while the pixel count is below `hs_width` (for `hsync`) or while the line is below `vs_width` (for `vsync`). With polarity bit 1 the asserted level is high; with polarity bit 0 it is low.
- R6: With `out_en` low, both sync pins sit at their inactive level (the inverse of their polarity bit) and `active` is 0.
- R7: `active` is 1 only when neither blank flag is set, `out_en` is 1 and `blank_all` is 0.
- R8: `irq_v1` and `irq_v2` each pulse for one cycle in the cycle after a pixel step lands on pixel 0 of line `vint1_line` or `vint2_line` respectively.
- R9: `irq_h` pulses for one cycle after a step lands on pixel `hint_pos`. Its line condition depends on `hint_mode`: code 0 fires only on line `hint_line`, code 2 fires on every line, and codes 1 and 3 never fire.
- R10: The `status` bit layout is:
  - bit CW+3: vblank
  - bit CW+2: hblank
  - bit CW+1: 0
  - bit CW: field
  - bits CW-1..0: current line
- R11: Synchronous active-high `rst` clears both counts and `field`, and no interrupt fires until the counters next step onto a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel step enable |
| out_en | input | 1 | Video output enable |
| blank_all | input | 1 | Force whole screen to border |
| interlace | input | 1 | Interlaced scanning select |
| hs_pol | input | 1 | 1 = hsync active high |
| vs_pol | input | 1 | 1 = vsync active high |
| h_total | input | CW | Last pixel index of a line |
| v_total | input | CW | Last line index of a frame |
| h_brd_start | input | CW | First active pixel |
| h_brd_end | input | CW | First blanked pixel after active |
| v_brd_start | input | CW | First active line |
| v_brd_end | input | CW | First blanked line after active |
| hs_width | input | CW | Hsync width in pixels |
| vs_width | input | CW | Vsync width in lines |
| vint1_line | input | CW | Line of first vertical interrupt |
| vint2_line | input | CW | Line of second vertical interrupt |
| hint_pos | input | CW | Pixel of horizontal interrupt |
| hint_line | input | CW | Line for horizontal interrupt code 0 |
| hint_mode | input | 2 | Horizontal interrupt mode code |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| field | output | 1 | Field bit |
| line_num | output | CW | Current line |
| active | output | 1 | Active picture |
| irq_v1 | output | 1 | First vertical interrupt pulse |
| irq_v2 | output | 1 | Second vertical interrupt pulse |
| irq_h | output | 1 | Horizontal interrupt pulse |
| status | output | CW+4 | Packed status word |

## Verification
The bench keeps the default counter width of 10 bits and programs a tiny raster of 16 pixels by 8 lines. This makes full frames, line and frame wraps, and interlace field toggles occur within a few hundred cycles. Border, sync and interrupt settings are placed well inside that raster, so every window edge and every interrupt is reached many times. Stall patterns on `pix_en` exercise the rule that an interrupt fires only once when a step lands on its match.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int MAX_W = 16;

    typedef enum logic [1:0] {
        HIRQ_ONE_LINE = 2'd0,
        HIRQ_RSV1     = 2'd1,
        HIRQ_EVERY    = 2'd2,
        HIRQ_RSV3     = 2'd3
    } hirq_mode_e;

    typedef struct packed {
        logic sync;
        logic blank;
    } axis_flags_t;

    // Half-open window test: start <= c < stop
    function automatic logic in_span(input logic [MAX_W-1:0] c,
                                     input logic [MAX_W-1:0] lo,
                                     input logic [MAX_W-1:0] hi);
        return (c >= lo) && (c < hi);
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic          interlace,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    output logic [CW-1:0] hcnt,
    output logic [CW-1:0] vcnt,
    output logic          field,
    output logic          stepped
);
    logic h_wrap, v_wrap;

    assign h_wrap = (hcnt >= h_total);
    assign v_wrap = (vcnt >= v_total);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt    <= '0;
            vcnt    <= '0;
            field   <= 1'b0;
            stepped <= 1'b0;
        end else begin
            stepped <= pix_en;
            if (pix_en) begin
                if (h_wrap) begin
                    hcnt <= '0;
                    if (v_wrap) begin
                        vcnt  <= '0;
                        field <= interlace ? ~field : 1'b0;
                    end else begin
                        vcnt <= vcnt + 1'b1;
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    p_h_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hcnt >= h_total) |=> (hcnt == '0));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(hcnt) && $stable(vcnt) && $stable(field)));

    p_field_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_en && h_wrap && v_wrap && interlace) |=> (field != $past(field)));

endmodule

// File: rtl/raster_axis.sv
module raster_axis #(
    parameter int CW = 10
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] span_start,
    input  logic [CW-1:0] span_end,
    input  logic [CW-1:0] pulse_width,
    input  logic          pol_high,
    input  logic          output_on,
    output logic          sync_pin,
    output logic          blank
);
    import raster_pkg::*;

    axis_flags_t fl;

    always_comb begin
        fl.sync  = (cnt < pulse_width);
        fl.blank = !in_span(MAX_W'(cnt), MAX_W'(span_start), MAX_W'(span_end));
        if (output_on)
            sync_pin = pol_high ? fl.sync : !fl.sync;
        else
            sync_pin = !pol_high;
        blank = fl.blank;
    end

endmodule

// File: rtl/raster_irq.sv
module raster_irq #(
    parameter int CW    = 10,
    parameter int NVIRQ = 2
) (
    input  logic [CW-1:0]    hcnt,
    input  logic [CW-1:0]    vcnt,
    input  logic             stepped,
    input  logic [CW-1:0]    vline [NVIRQ],
    input  logic [CW-1:0]    hpos,
    input  logic [CW-1:0]    hline,
    input  logic [1:0]       hmode,
    output logic [NVIRQ-1:0] irq_v,
    output logic             irq_h
);
    import raster_pkg::*;

    logic h_line_ok;

    for (genvar i = 0; i < NVIRQ; i++) begin : g_vint
        assign irq_v[i] = stepped && (hcnt == '0) && (vcnt == vline[i]);
    end

    always_comb begin
        case (hirq_mode_e'(hmode))
            HIRQ_ONE_LINE: h_line_ok = (vcnt == hline);
            HIRQ_EVERY:    h_line_ok = 1'b1;
            default:       h_line_ok = 1'b0;
        endcase
        irq_h = stepped && (hcnt == hpos) && h_line_ok;
    end

endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic          out_en,
    input  logic          blank_all,
    input  logic          interlace,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    input  logic [CW-1:0] h_brd_start,
    input  logic [CW-1:0] h_brd_end,
    input  logic [CW-1:0] v_brd_start,
    input  logic [CW-1:0] v_brd_end,
    input  logic [CW-1:0] hs_width,
    input  logic [CW-1:0] vs_width,
    input  logic [CW-1:0] vint1_line,
    input  logic [CW-1:0] vint2_line,
    input  logic [CW-1:0] hint_pos,
    input  logic [CW-1:0] hint_line,
    input  logic [1:0]    hint_mode,
    output logic          hsync,
    output logic          vsync,
    output logic          hblank,
    output logic          vblank,
    output logic          field,
    output logic [CW-1:0] line_num,
    output logic          active,
    output logic          irq_v1,
    output logic          irq_v2,
    output logic          irq_h,
    output logic [CW+3:0] status
);
    localparam int NAX   = 2;
    localparam int NVIRQ = 2;

    logic [CW-1:0]    hcnt, vcnt;
    logic             stepped;
    logic [CW-1:0]    ax_cnt   [NAX];
    logic [CW-1:0]    ax_start [NAX];
    logic [CW-1:0]    ax_end   [NAX];
    logic [CW-1:0]    ax_width [NAX];
    logic             ax_pol   [NAX];
    logic             ax_sync  [NAX];
    logic             ax_blank [NAX];
    logic [CW-1:0]    vlines   [NVIRQ];
    logic [NVIRQ-1:0] irq_v;

    raster_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .pix_en(pix_en), .interlace(interlace),
        .h_total(h_total), .v_total(v_total),
        .hcnt(hcnt), .vcnt(vcnt), .field(field), .stepped(stepped)
    );

    assign ax_cnt[0]   = hcnt;
    assign ax_cnt[1]   = vcnt;
    assign ax_start[0] = h_brd_start;
    assign ax_start[1] = v_brd_start;
    assign ax_end[0]   = h_brd_end;
    assign ax_end[1]   = v_brd_end;
    assign ax_width[0] = hs_width;
    assign ax_width[1] = vs_width;
    assign ax_pol[0]   = hs_pol;
    assign ax_pol[1]   = vs_pol;

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        raster_axis #(.CW(CW)) u_axis (
            .cnt(ax_cnt[a]), .span_start(ax_start[a]), .span_end(ax_end[a]),
            .pulse_width(ax_width[a]), .pol_high(ax_pol[a]), .output_on(out_en),
            .sync_pin(ax_sync[a]), .blank(ax_blank[a])
        );
    end

    assign vlines[0] = vint1_line;
    assign vlines[1] = vint2_line;

    raster_irq #(.CW(CW), .NVIRQ(NVIRQ)) u_irq (
        .hcnt(hcnt), .vcnt(vcnt), .stepped(stepped), .vline(vlines),
        .hpos(hint_pos), .hline(hint_line), .hmode(hint_mode),
        .irq_v(irq_v), .irq_h(irq_h)
    );

    assign hsync    = ax_sync[0];
    assign vsync    = ax_sync[1];
    assign hblank   = ax_blank[0];
    assign vblank   = ax_blank[1];
    assign line_num = vcnt;
    assign active   = out_en && !blank_all && !ax_blank[0] && !ax_blank[1];
    assign irq_v1   = irq_v[0];
    assign irq_v2   = irq_v[1];
    assign status   = {ax_blank[1], ax_blank[0], 1'b0, field, vcnt};

    p_active_r7: assert property (@(posedge clk) disable iff (rst)
        active |-> (!hblank && !vblank && out_en && !blank_all));

    p_sync_off_r6: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> ((hsync == !hs_pol) && (vsync == !vs_pol) && !active));

    p_irq_v1_once_r8: assert property (@(posedge clk) disable iff (rst)
        (h_total != '0 && irq_v1) |=> !irq_v1);

    p_irq_h_once_r9: assert property (@(posedge clk) disable iff (rst)
        (h_total != '0 && irq_h) |=> !irq_h);

endmodule

// File: tb/sim_raster_timer.sv
module sim_raster_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst, pix_en, out_en, blank_all, interlace, hs_pol, vs_pol;
    logic [CW-1:0] h_total, v_total, h_brd_start, h_brd_end, v_brd_start, v_brd_end;
    logic [CW-1:0] hs_width, vs_width, vint1_line, vint2_line, hint_pos, hint_line;
    logic [1:0] hint_mode;
    logic hsync, vsync, hblank, vblank, field, active, irq_v1, irq_v2, irq_h;
    logic [CW-1:0] line_num;
    logic [CW+3:0] status;

    raster_timer #(.CW(CW)) u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mh, mv;
    logic mf, mstep;

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, exp, mh, mv);
        end
    endtask

    task automatic check_all();
        logic ehb, evb, ehs, evs, eact, ev1, ev2, eh, lok;
        ehb = !((mh >= int'(h_brd_start)) && (mh < int'(h_brd_end)));
        evb = !((mv >= int'(v_brd_start)) && (mv < int'(v_brd_end)));
        ehs = out_en ? (hs_pol ? (mh < int'(hs_width)) : !(mh < int'(hs_width))) : !hs_pol;
        evs = out_en ? (vs_pol ? (mv < int'(vs_width)) : !(mv < int'(vs_width))) : !vs_pol;
        eact = out_en && !blank_all && !ehb && !evb;
        ev1 = mstep && mh == 0 && mv == int'(vint1_line);
        ev2 = mstep && mh == 0 && mv == int'(vint2_line);
        lok = (hint_mode == 2'd0) ? (mv == int'(hint_line)) : (hint_mode == 2'd2);
        eh = mstep && mh == int'(hint_pos) && lok;
        chk_eq("R1 R2 line", int'(line_num), mv);
        chk_eq("R3 field", int'(field), int'(mf));
        chk_eq("R4 hblank", int'(hblank), int'(ehb));
        chk_eq("R4 vblank", int'(vblank), int'(evb));
        chk_eq("R5 R6 hsync", int'(hsync), int'(ehs));
        chk_eq("R5 R6 vsync", int'(vsync), int'(evs));
        chk_eq("R6 R7 active", int'(active), int'(eact));
        chk_eq("R8 irq_v1", int'(irq_v1), int'(ev1));
        chk_eq("R8 irq_v2", int'(irq_v2), int'(ev2));
        chk_eq("R9 irq_h", int'(irq_h), int'(eh));
        chk_eq("R10 status", int'(status), int'({evb, ehb, 1'b0, mf, 10'(mv)}));
    endtask

    task automatic tick(input bit en);
        pix_en = en;
        @(posedge clk);
        #1;
        if (en) begin
            if (mh >= int'(h_total)) begin
                mh = 0;
                if (mv >= int'(v_total)) begin
                    mv = 0;
                    mf = interlace ? ~mf : 1'b0;
                end else mv++;
            end else mh++;
        end
        mstep = en;
        pix_en = 1'b0;
        check_all();
    endtask

    task automatic t_reset();
        rst = 1'b1; pix_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        mh = 0; mv = 0; mf = 1'b0; mstep = 1'b0;
        chk_eq("R11 reset line", int'(line_num), 0);
        chk_eq("R11 reset field", int'(field), 0);
        chk_eq("R11 reset irqs", int'({irq_v1, irq_v2, irq_h}), 0);
        check_all();
    endtask

    task automatic t_interlace();
        interlace = 1'b1; hs_pol = 1'b1; vs_pol = 1'b1;
        t_reset();
        for (int i = 0; i < 300; i++) tick(1'b1);
    endtask

    task automatic t_polarity();
        interlace = 1'b0; hs_pol = 1'b0; vs_pol = 1'b0;
        t_reset();
        for (int i = 0; i < 140; i++) tick(1'b1);
        hs_pol = 1'b1;
    endtask

    task automatic t_hmodes();
        for (int m = 1; m < 4; m++) begin
            hint_mode = 2'(m);
            for (int i = 0; i < 130; i++) tick(1'b1);
        end
        hint_mode = 2'd0;
    endtask

    task automatic t_stall();
        interlace = 1'b1;
        for (int i = 0; i < 300; i++) tick((i % 3) != 0);
        for (int i = 0; i < 5; i++) tick(1'b0);
    endtask

    task automatic t_disable();
        out_en = 1'b0;
        for (int i = 0; i < 60; i++) tick(1'b1);
        out_en = 1'b1; blank_all = 1'b1;
        for (int i = 0; i < 60; i++) tick(1'b1);
        blank_all = 1'b0;
        for (int i = 0; i < 20; i++) tick(1'b1);
    endtask

    initial begin
        rst = 1'b1; pix_en = 1'b0; out_en = 1'b1; blank_all = 1'b0;
        interlace = 1'b0; hs_pol = 1'b1; vs_pol = 1'b1;
        h_total = 10'd15; v_total = 10'd7;
        h_brd_start = 10'd3; h_brd_end = 10'd12;
        v_brd_start = 10'd1; v_brd_end = 10'd6;
        hs_width = 10'd2; vs_width = 10'd1;
        vint1_line = 10'd2; vint2_line = 10'd5;
        hint_pos = 10'd7; hint_line = 10'd3; hint_mode = 2'd0;
        mh = 0; mv = 0; mf = 1'b0; mstep = 1'b0;
        t_interlace();
        t_polarity();
        t_hmodes();
        t_stall();
        t_disable();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule